// File: doc/BRIEF.md
# Parallel Adder Self-Test Sequencer

This block runs the built-in self-test of two 16-bit adders that share one pseudo-random pattern source. While the mode input is low the adders take their functional operands and the sequencer stays quiet. When the mode input is sampled high on a clock edge, functional operation is suspended. The block then seeds the shared pattern source and clears both signature registers in one cycle. It lets the source and both signature registers step together for a fixed number of cycles. After that it checks both signatures against one expected constant in a single cycle.

The result is two level outputs: a completion flag and a pass/fail flag that goes high if either unit's signature is wrong. Both stay put until the mode input is dropped. The pattern source, the signature registers and the adders are outside this block. It only drives their enables, their seed or clear strobes and the operand select, and it reads back the two signatures on a packed bus.

Top module: `dual_adder_bist_ctrl`

## Requirements
- R1: Asynchronous reset (rst_n low) immediately forces test_done=0, test_report=0, test_sel=0 and gen_load, gen_en, misr_clr and misr_en all 0, whatever the clock.
- R2: While testmode is low and no test is in progress, test_sel stays 0 (functional operands) and all four generator and signature-register controls stay 0.
- R3: On the first clock edge that samples testmode high in idle, the block enters a single initialisation cycle in which gen_load=1, misr_clr=1, test_sel=1, and gen_en and misr_en are 0.
- R4: Directly after the initialisation cycle, gen_en and misr_en are both 1 for exactly 324 consecutive cycles (RUN_CYCLES), with test_sel=1. They are 0 in the comparison cycle that follows.
- R5: test_done goes to 1 on exactly the 326th clock edge after the edge that sampled testmode high. It is 0 on every earlier edge.
- R6: If both signatures equal 16'h5C84 during the comparison cycle (the cycle just before test_done rises), test_report is 0. Unit 0's signature is on sig_bus[15:0] and unit 1's is on sig_bus[31:16].
- R7: If either unit's signature differs from 16'h5C84 in any bit during the comparison cycle, test_report is 1 when test_done rises.
- R8: While testmode stays high after completion, test_done and test_report hold their values, even if sig_bus changes.
- R9: When testmode is sampled low with test_done high, on that edge test_done, test_report and test_sel all return to 0.
- R10: If testmode is sampled low at any point before completion, the sequence aborts on that edge: test_sel and all controls go to 0, and test_done does not rise.
- R11: The value of sig_bus outside the comparison cycle has no effect on test_report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| testmode | input | 1 | 1 requests self-test, 0 functional operation; sampled on the clock |
| sig_bus | input | 32 | Final signatures, unit 0 in [15:0], unit 1 in [31:16] |
| test_sel | output | 1 | Adder operand select: 1 pattern source, 0 functional |
| gen_load | output | 1 | Seed strobe for the shared pattern generator |
| gen_en | output | 1 | Step enable for the pattern generator |
| misr_clr | output | 1 | Clear strobe for both signature registers |
| misr_en | output | 1 | Capture enable for both signature registers |
| test_done | output | 1 | Self-test complete |
| test_report | output | 1 | 1 if any unit's signature mismatched |

## Verification
Full test runs are driven with signature pairs in which both units match, only unit 0 is wrong, only unit 1 is wrong, both are wrong, and a single low or high bit is flipped. These separate a compare that checks only one lane, or only part of a lane, from a correct one. A run that carries wrong signatures during the pattern phase and correct ones in the comparison cycle shows that the check is taken in the right cycle. Directed runs drop testmode in the middle of the pattern phase and after completion, and apply reset in the middle of a run, to tell abort and release apart from hold.

// File: rtl/dabist_pkg.sv
package dabist_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_INIT = 3'd1,
      ST_RUN  = 3'd2,
      ST_CMP  = 3'd3,
      ST_DONE = 3'd4
   } seq_state_e;

   localparam int unsigned DEF_SIG_W      = 16;
   localparam int unsigned DEF_N_UNITS    = 2;
   localparam int unsigned DEF_RUN_CYCLES = 324;

endpackage

// File: rtl/dabist_run_cnt.sv
module dabist_run_cnt #(
   parameter int unsigned RUN_CYCLES = 324
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic last
);
   localparam int unsigned CW = (RUN_CYCLES > 2) ? $clog2(RUN_CYCLES) : 1;
   localparam logic [CW-1:0] LAST_V = CW'(RUN_CYCLES - 1);

   generate
      if (RUN_CYCLES < 2) begin : g_bad_len
         $error("RUN_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (adv && (cnt_q != LAST_V)) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign last = adv && (cnt_q == LAST_V);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_V);  // R4
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));  // R4

endmodule

// File: rtl/dabist_sig_cmp.sv
module dabist_sig_cmp #(
   parameter int unsigned       N_UNITS = 2,
   parameter int unsigned       SIG_W   = 16,
   parameter logic [SIG_W-1:0]  EXP_SIG = 16'h5C84
) (
   input  logic [N_UNITS*SIG_W-1:0] sig_bus,
   output logic                     mismatch
);
   generate
      if (N_UNITS < 1) begin : g_bad_units
         $error("N_UNITS must be at least 1");
      end
      if (SIG_W < 2) begin : g_bad_width
         $error("SIG_W must be at least 2");
      end
   endgenerate

   logic [N_UNITS-1:0] lane_bad;

   generate
      for (genvar g = 0; g < N_UNITS; g++) begin : g_lane
         assign lane_bad[g] = (sig_bus[g*SIG_W +: SIG_W] != EXP_SIG);
      end
   endgenerate

   assign mismatch = |lane_bad;

endmodule

// File: rtl/dabist_fsm.sv
module dabist_fsm
   import dabist_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       testmode,
   input  logic       run_last,
   input  logic       mismatch,
   output seq_state_e state,
   output logic       test_done,
   output logic       test_report
);
   seq_state_e state_q, state_d;
   logic       done_q, rep_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: state_d = testmode ? ST_INIT : ST_IDLE;
         ST_INIT: state_d = testmode ? ST_RUN  : ST_IDLE;
         ST_RUN : begin
            if (!testmode)     state_d = ST_IDLE;
            else if (run_last) state_d = ST_CMP;
            else               state_d = ST_RUN;
         end
         ST_CMP : state_d = testmode ? ST_DONE : ST_IDLE;
         ST_DONE: state_d = testmode ? ST_DONE : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         rep_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!testmode) begin
            done_q <= 1'b0;
            rep_q  <= 1'b0;
         end else if (state_q == ST_CMP) begin
            done_q <= 1'b1;
            rep_q  <= mismatch;
         end
      end
   end

   assign state       = state_q;
   assign test_done   = done_q;
   assign test_report = rep_q;

   AST_ENTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && testmode) |=> (state_q == ST_INIT));  // R3
   AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INIT) |=> (state_q != ST_INIT));  // R3
   AST_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_done) |-> ($past(state_q) == ST_CMP));  // R5
   AST_REPORT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_done) |-> (test_report == $past(mismatch)));  // R6
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (test_done && testmode) |=> (test_done && $stable(test_report)));  // R8
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (test_done && !testmode) |=> (!test_done && state_q == ST_IDLE));  // R9
   AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !testmode) |=> (state_q == ST_IDLE && !test_done));  // R10
   AST_REPORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !test_done |-> !test_report);  // R9

endmodule

// File: rtl/dual_adder_bist_ctrl.sv
module dual_adder_bist_ctrl
   import dabist_pkg::*;
#(
   parameter int unsigned            SIG_W      = DEF_SIG_W,
   parameter int unsigned            N_UNITS    = DEF_N_UNITS,
   parameter int unsigned            RUN_CYCLES = DEF_RUN_CYCLES,
   parameter logic [SIG_W-1:0]       EXP_SIG    = 16'h5C84
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     testmode,
   input  logic [N_UNITS*SIG_W-1:0] sig_bus,
   output logic                     test_sel,
   output logic                     gen_load,
   output logic                     gen_en,
   output logic                     misr_clr,
   output logic                     misr_en,
   output logic                     test_done,
   output logic                     test_report
);
   seq_state_e st;
   logic       run_last;
   logic       mismatch;
   logic       in_init, in_run;

   assign in_init = (st == ST_INIT);
   assign in_run  = (st == ST_RUN);

   dabist_run_cnt #(
      .RUN_CYCLES(RUN_CYCLES)
   ) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (in_init),
      .adv  (in_run),
      .last (run_last)
   );

   dabist_sig_cmp #(
      .N_UNITS(N_UNITS),
      .SIG_W  (SIG_W),
      .EXP_SIG(EXP_SIG)
   ) u_cmp (
      .sig_bus (sig_bus),
      .mismatch(mismatch)
   );

   dabist_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .testmode   (testmode),
      .run_last   (run_last),
      .mismatch   (mismatch),
      .state      (st),
      .test_done  (test_done),
      .test_report(test_report)
   );

   assign test_sel = (st != ST_IDLE);
   assign gen_load = in_init;
   assign misr_clr = in_init;
   assign gen_en   = in_run;
   assign misr_en  = in_run;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!testmode && !test_sel) |=> (!test_sel && !gen_en && !misr_en));  // R2
   AST_RUN_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (misr_clr && testmode) |=> (gen_en && misr_en && test_sel));  // R4

endmodule

// File: tb/dual_adder_bist_ctrl_tb_top.sv
module dual_adder_bist_ctrl_tb_top;
   localparam int unsigned RUN_N = 324;
   localparam logic [15:0] GOOD  = 16'h5C84;

   // {expected report, unit-1 signature, unit-0 signature}
   localparam logic [32:0] VEC [6] = '{
      {1'b0, 16'h5C84, 16'h5C84},
      {1'b1, 16'h5C84, 16'h0000},
      {1'b1, 16'hFFFF, 16'h5C84},
      {1'b1, 16'h1234, 16'hA5A5},
      {1'b1, 16'h5C84, 16'h5C85},
      {1'b1, 16'hDC84, 16'h5C84}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        testmode = 1'b0;
   logic [31:0] sig_bus = '0;
   logic test_sel, gen_load, gen_en, misr_clr, misr_en, test_done, test_report;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dual_adder_bist_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .testmode(testmode), .sig_bus(sig_bus),
      .test_sel(test_sel), .gen_load(gen_load), .gen_en(gen_en),
      .misr_clr(misr_clr), .misr_en(misr_en),
      .test_done(test_done), .test_report(test_report)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ctrl_word(output logic [31:0] w);
      w = {25'd0, test_sel, gen_load, gen_en, misr_clr, misr_en, test_done, test_report};
   endtask

   task automatic full_run(input logic [15:0] ra, input logic [15:0] rb,
                           input logic [15:0] fa, input logic [15:0] fb,
                           input logic exp_rep, input string rep_tag);
      int run_ok;
      logic [31:0] w;
      testmode = 1'b1;
      sig_bus  = {rb, ra};
      tick();
      ctrl_word(w);
      check("R3 init cycle controls", w, 32'b1101_0000 >> 1);
      run_ok = 0;
      for (int k = 1; k <= RUN_N; k++) begin
         tick();
         if (gen_en && misr_en && test_sel && !gen_load && !misr_clr && !test_done)
            run_ok++;
      end
      check("R4 enabled run cycles", run_ok, RUN_N);
      sig_bus = {fb, fa};
      tick();
      check("R4 enables off in compare cycle", {gen_en, misr_en}, 0);
      check("R5 done low at edge 325", test_done, 0);
      tick();
      check("R5 done high at edge 326", test_done, 1);
      check(rep_tag, test_report, exp_rep);
      sig_bus = ~sig_bus;
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R8 hold after completion", {test_done, test_report}, {1'b1, exp_rep});
      end
      testmode = 1'b0;
      tick();
      check("R9 release on testmode low", {test_done, test_report, test_sel}, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      int done_seen;
      #3;
      ctrl_word(w);
      check("R1 reset state", w, 0);
      #10;
      rst_n = 1'b1;
      tick();
      // R2: idle with testmode low
      for (int k = 0; k < 5; k++) begin
         sig_bus = 32'hDEAD_0000 + k;
         tick();
         ctrl_word(w);
         check("R2 idle quiet", w, 0);
      end
      // table of signature pairs
      for (int i = 0; i < 6; i++) begin
         full_run(VEC[i][15:0], VEC[i][31:16], VEC[i][15:0], VEC[i][31:16],
                  VEC[i][32], VEC[i][32] ? "R7 report on mismatch" : "R6 report on match");
         tick();
      end
      // R11: wrong signatures during run, correct in compare cycle
      full_run(16'h0BAD, 16'hBEEF, GOOD, GOOD, 1'b0, "R11 only compare cycle counts");
      tick();
      // R10: abort in the middle of the pattern phase
      testmode = 1'b1;
      for (int k = 0; k < 50; k++) tick();
      check("R10 running before abort", gen_en, 1);
      testmode = 1'b0;
      tick();
      ctrl_word(w);
      check("R10 abort to idle", w, 0);
      done_seen = 0;
      for (int k = 0; k < 330; k++) begin
         tick();
         if (test_done || test_sel) done_seen++;
      end
      check("R10 no completion after abort", done_seen, 0);
      // R1: asynchronous reset mid-run
      testmode = 1'b1;
      for (int k = 0; k < 20; k++) tick();
      #2;
      rst_n = 1'b0;
      #1;
      ctrl_word(w);
      check("R1 async reset mid-run", w, 0);
      testmode = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      ctrl_word(w);
      check("R1 idle after reset release", w, 0);
      // restart after reset gives a clean full run
      full_run(GOOD, GOOD, GOOD, GOOD, 1'b0, "R6 report on match after reset");
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule